// File: doc/BRIEF.md
# HDLC Frame Receiver with Address Filter

This block turns a recovered serial bit stream into frame bytes. Bits arrive one at a time on `bit_in`, qualified by `bit_valid`. The block hunts for the flag pattern and removes the zeros the transmitter inserted after runs of ones. It assembles bytes least significant bit first and marks where each frame starts and ends. A run of seven or more ones is an abort: it kills the frame in progress.

An optional address filter looks at the start of each frame and silently drops frames that do not match. In single-byte mode, the whole first byte is compared against four programmable addresses. In paired mode, the first two bytes are compared against two address pairs. The frame check sequence (CRC-16, the ITU-T polynomial, preset to ones) is verified over the whole frame. The two check bytes can be removed from the output or passed on.

Output is a byte stream. Each frame is closed by a separate end-of-frame beat carrying error and abort status. Output runs two bytes behind the line, because the last two bytes of a frame cannot be identified as check bytes until the closing flag arrives. A two-bit state output tells whether the line is idle or hunting, sitting between frames on flags, or inside a frame.

Top module: `hdlc_rx_filter`

## Requirements
- R1: After reset, and on the cycle after any cycle with `enable` low, `line_state` is 2'b00 (idle/hunt) and no output beat is produced. The first flag seen while enabled moves `line_state` to 2'b01 (between frames), and 2'b11 never appears.
- R2: A 0 bit that follows five consecutive 1 bits is removed from the data. Bytes are assembled with the first received bit as bit 0.
- R3: A 0 bit after exactly six 1 bits is a flag. The first complete byte after a flag that is neither a flag nor an abort starts a frame, and `line_state` reads 2'b10 while the frame is in progress.
- R4: Seven consecutive 1 bits inside a frame that has not been rejected produce an end-of-frame beat with `out_abort` high and `out_err` low. No further bytes of that frame are output, and `line_state` returns to 2'b00.
- R5: With `filt_en` high and `filt_two_byte` low, the frame is kept only if its full first byte equals one of the four address registers (register k is `filt_addrs[8k+7:8k]`).
- R6: With `filt_en` high and `filt_two_byte` high, the frame is kept only if its first and second bytes equal registers 0 and 1 in that order, or registers 2 and 3 in that order.
- R7: No address bit gets special meaning: every bit of the compared byte counts, including bit 0. A frame that fails the filter produces no output beat at all, and the receiver goes back to hunting (`line_state` 2'b00).
- R8: At the closing flag, the held bytes that still belong in the output are delivered, followed by exactly one beat with `out_eof` high and `out_valid` low.
- R9: With `fcs_check` high, `out_err` is set on the end-of-frame beat when the CRC register, run over all frame bytes including the check bytes, does not hold 0xF0B8.
- R10: With `fcs_check` high and `fcs_keep` low, the last two frame bytes are not output. With `fcs_keep` high, or with `fcs_check` low, every frame byte is output, and with `fcs_check` low a wrong check value raises no error.
- R11: A frame of fewer than three bytes, check bytes included, ends with `out_err` high.
- R12: `out_valid` and `out_eof` are never high in the same cycle, and `out_err` and `out_abort` are high only on an end-of-frame beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Receiver enable; low forces hunt state |
| bit_valid | input | 1 | `bit_in` carries a new line bit this cycle |
| bit_in | input | 1 | Recovered line bit |
| filt_en | input | 1 | Address filtering on |
| filt_two_byte | input | 1 | 0: single-byte match on four registers; 1: paired two-byte match |
| filt_addrs | input | 32 | Four address registers, register k at bits 8k+7:8k |
| fcs_check | input | 1 | Verify the frame check sequence |
| fcs_keep | input | 1 | Pass the check bytes to the output when checking |
| out_valid | output | 1 | Data byte beat |
| out_data | output | 8 | Frame byte |
| out_eof | output | 1 | End-of-frame beat |
| out_err | output | 1 | Check, length or alignment error (on end-of-frame beat) |
| out_abort | output | 1 | Frame aborted (on end-of-frame beat) |
| line_state | output | 2 | 00 idle/hunt, 01 between frames on flags, 10 in frame |

## Verification
Frames are sent with random payloads, random bit gaps and random filter and check settings. Payload bytes such as 0xFF, 0x7E and 0x3F force stuffing in and around the check bytes, so a destuffing or byte alignment fault shows up as corrupted data. Directed address bytes separate each single-byte register and each correct and crossed address pair. A byte that differs from a register only in bit 0 shows whether the low address bit is masked. Good, corrupted and short frames, tried under every strip, keep and bypass setting, separate the residue test from the length test and the byte-hold logic. Aborts in the middle of a frame and back-to-back frames sharing flags exercise the frame delimiting.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    LS_MARK  = 2'b00,
    LS_FLAGS = 2'b01,
    LS_DATA  = 2'b10
  } line_state_e;

  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_LE = 16'h8408;

  // Bit-serial CRC-16 update, least significant bit of the byte first.
  function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [7:0] data);
    logic [15:0] c;
    logic        fb;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ data[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_LE;
    end
    return c;
  endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int STUFF_RUN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic       ev_flag,
  output logic       ev_abort,
  output logic       ev_byte,
  output logic [7:0] byte_val,
  output logic       aligned
);
  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int CW        = $clog2(ABORT_RUN + 1);
  localparam logic [CW-1:0] K_STUFF = CW'(STUFF_RUN);
  localparam logic [CW-1:0] K_FLAG  = CW'(FLAG_RUN);
  localparam logic [CW-1:0] K_ABORT = CW'(ABORT_RUN);
  // Bits pushed from the flag itself: its leading zero plus STUFF_RUN ones.
  localparam logic [2:0]    K_TAIL  = 3'(STUFF_RUN + 1);

  logic [CW-1:0] ones_q, ones_d;
  logic [6:0]    sr_q;
  logic [2:0]    bcnt_q;
  logic          push;

  always_comb begin
    ones_d   = ones_q;
    push     = 1'b0;
    ev_flag  = 1'b0;
    ev_abort = 1'b0;
    if (enable && bit_valid) begin
      if (bit_in) begin
        ones_d   = (ones_q == K_ABORT) ? ones_q : ones_q + 1'b1;
        push     = (ones_q < K_STUFF);
        ev_abort = (ones_q == K_FLAG);
      end else begin
        ones_d  = '0;
        ev_flag = (ones_q == K_FLAG);
        push    = (ones_q != K_STUFF) && (ones_q != K_FLAG);
      end
    end
  end

  assign ev_byte  = push && (bcnt_q == 3'd7);
  assign byte_val = {bit_in, sr_q};
  assign aligned  = (bcnt_q == K_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      sr_q   <= '0;
      bcnt_q <= '0;
    end else if (!enable) begin
      ones_q <= '0;
      bcnt_q <= '0;
    end else begin
      ones_q <= ones_d;
      if (push) begin
        sr_q   <= {bit_in, sr_q[6:1]};
        bcnt_q <= bcnt_q + 3'd1;
      end
      if (ev_flag) bcnt_q <= '0;
    end
  end

endmodule

// File: rtl/hdlc_rx_addr_match.sv
module hdlc_rx_addr_match #(
  parameter int N_ADDR = 4
) (
  input  logic [N_ADDR*8-1:0] table_in,
  input  logic [7:0]          byte_in,
  input  logic [N_ADDR/2-1:0] pair_hit_q,
  output logic                hit_any,
  output logic [N_ADDR/2-1:0] first_hits,
  output logic                second_ok
);
  localparam int NPAIR = N_ADDR / 2;

  logic [N_ADDR-1:0] eq;
  logic [NPAIR-1:0]  second_hits;

  for (genvar k = 0; k < N_ADDR; k++) begin : g_cmp
    assign eq[k] = (table_in[8*k +: 8] == byte_in);
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign first_hits[p]  = eq[2*p];
    assign second_hits[p] = eq[2*p+1] & pair_hit_q[p];
  end

  assign hit_any   = |eq;
  assign second_ok = |second_hits;

endmodule

// File: rtl/hdlc_rx_fcs_acc.sv
module hdlc_rx_fcs_acc
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       update,
  input  logic [7:0] byte_in,
  output logic       good
);
  logic [15:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_PRESET;
    else if (start)  crc_q <= crc16_step(CRC_PRESET, byte_in);
    else if (update) crc_q <= crc16_step(crc_q, byte_in);
  end

  assign good = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter
  import hdlc_rx_pkg::*;
#(
  parameter int N_ADDR    = 4,
  parameter int FCS_BYTES = 2,
  parameter int STUFF_RUN = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                bit_valid,
  input  logic                bit_in,
  input  logic                filt_en,
  input  logic                filt_two_byte,
  input  logic [N_ADDR*8-1:0] filt_addrs,
  input  logic                fcs_check,
  input  logic                fcs_keep,
  output logic                out_valid,
  output logic [7:0]          out_data,
  output logic                out_eof,
  output logic                out_err,
  output logic                out_abort,
  output logic [1:0]          line_state
);
  localparam int NPAIR   = N_ADDR / 2;
  localparam int MIN_LEN = FCS_BYTES + 1;
  localparam int NB_W    = $clog2(MIN_LEN + 1);
  localparam int PC_W    = $clog2(FCS_BYTES + 1);
  localparam logic [NB_W-1:0] NB_MIN  = NB_W'(MIN_LEN);
  localparam logic [NB_W-1:0] NB_ONE  = NB_W'(1);
  localparam logic [PC_W-1:0] PC_FULL = PC_W'(FCS_BYTES);

  // Internal events, named for the checker
  logic       ev_flag, ev_abort, ev_byte, aligned;
  logic [7:0] byte_val;
  logic       frame_byte, is_first, on_second, frame_reject, frame_take;
  logic       strip_fcs, end_err, crc_good;
  logic       hit_any, second_ok;
  logic [NPAIR-1:0] first_hits, pair_hit_q;

  line_state_e     state_q;
  logic [NB_W-1:0] nbytes_q;
  logic [7:0]      pipe_q [FCS_BYTES];
  logic [PC_W-1:0] pcnt_q;
  logic            drain_q, pend_err_q;

  hdlc_rx_deframer #(.STUFF_RUN(STUFF_RUN)) u_deframer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bit_valid(bit_valid), .bit_in(bit_in),
    .ev_flag(ev_flag), .ev_abort(ev_abort), .ev_byte(ev_byte), .byte_val(byte_val),
    .aligned(aligned)
  );

  hdlc_rx_addr_match #(.N_ADDR(N_ADDR)) u_addr (
    .table_in(filt_addrs), .byte_in(byte_val), .pair_hit_q(pair_hit_q),
    .hit_any(hit_any), .first_hits(first_hits), .second_ok(second_ok)
  );

  assign frame_byte = ev_byte && ((state_q == LS_FLAGS) || (state_q == LS_DATA));
  assign is_first   = (state_q == LS_FLAGS);
  assign on_second  = (state_q == LS_DATA) && (nbytes_q == NB_ONE);
  assign frame_reject = frame_byte && filt_en &&
                        ((is_first && !filt_two_byte && !hit_any) ||
                         (on_second && filt_two_byte && !second_ok));
  assign frame_take = frame_byte && !frame_reject;
  assign strip_fcs  = fcs_check && !fcs_keep;
  assign end_err    = !aligned || (nbytes_q < NB_MIN) || (fcs_check && !crc_good);

  hdlc_rx_fcs_acc u_fcs (
    .clk(clk), .rst_n(rst_n),
    .start(frame_take && is_first), .update(frame_take && !is_first),
    .byte_in(byte_val), .good(crc_good)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LS_MARK;
      nbytes_q   <= '0;
      pair_hit_q <= '0;
      pcnt_q     <= '0;
      drain_q    <= 1'b0;
      pend_err_q <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_eof    <= 1'b0;
      out_err    <= 1'b0;
      out_abort  <= 1'b0;
      for (int k = 0; k < FCS_BYTES; k++) pipe_q[k] <= '0;
    end else begin
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
      out_err   <= 1'b0;
      out_abort <= 1'b0;
      if (!enable) begin
        state_q <= LS_MARK;
        pcnt_q  <= '0;
        drain_q <= 1'b0;
      end else begin
        // Drain held bytes, then the end-of-frame beat
        if (drain_q) begin
          if (pcnt_q != '0) begin
            out_valid <= 1'b1;
            out_data  <= pipe_q[0];
            for (int k = 0; k < FCS_BYTES - 1; k++) pipe_q[k] <= pipe_q[k+1];
            pcnt_q <= pcnt_q - 1'b1;
          end else begin
            out_eof <= 1'b1;
            out_err <= pend_err_q;
            drain_q <= 1'b0;
          end
        end
        case (state_q)
          LS_MARK: begin
            if (ev_flag) state_q <= LS_FLAGS;
          end
          LS_FLAGS: begin
            if (ev_abort) begin
              state_q <= LS_MARK;
            end else if (frame_reject) begin
              state_q <= LS_MARK;
            end else if (frame_take) begin
              state_q    <= LS_DATA;
              nbytes_q   <= NB_ONE;
              pair_hit_q <= first_hits;
              pipe_q[0]  <= byte_val;
              pcnt_q     <= PC_W'(1);
            end
          end
          LS_DATA: begin
            if (ev_abort) begin
              out_eof   <= 1'b1;
              out_abort <= 1'b1;
              pcnt_q    <= '0;
              state_q   <= LS_MARK;
            end else if (ev_flag) begin
              state_q    <= LS_FLAGS;
              drain_q    <= 1'b1;
              pend_err_q <= end_err;
              if (strip_fcs) pcnt_q <= '0;
            end else if (frame_reject) begin
              pcnt_q  <= '0;
              state_q <= LS_MARK;
            end else if (frame_take) begin
              if (nbytes_q != NB_MIN) nbytes_q <= nbytes_q + 1'b1;
              if (pcnt_q == PC_FULL) begin
                out_valid <= 1'b1;
                out_data  <= pipe_q[0];
                for (int k = 0; k < FCS_BYTES - 1; k++) pipe_q[k] <= pipe_q[k+1];
                pipe_q[FCS_BYTES-1] <= byte_val;
              end else begin
                pipe_q[pcnt_q] <= byte_val;
                pcnt_q         <= pcnt_q + 1'b1;
              end
            end
          end
          default: state_q <= LS_MARK;
        endcase
      end
    end
  end

  assign line_state = state_q;

endmodule

// File: rtl/hdlc_rx_filter_chk.sv
module hdlc_rx_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       out_valid,
  input logic       out_eof,
  input logic       out_err,
  input logic       out_abort,
  input logic [1:0] line_state,
  input logic       ev_flag,
  input logic       ev_abort,
  input logic       ev_byte,
  input logic       frame_reject
);

  assert_beat_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_eof));

  assert_status_on_eof_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_err || out_abort) |-> out_eof);

  assert_abort_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> !out_err);

  assert_abort_to_hunt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> (line_state == 2'b00));

  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((line_state == 2'b00) && !out_valid && !out_eof));

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_state != 2'b11);

  assert_events_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_flag, ev_abort, ev_byte}));

  assert_reject_hunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_reject |=> ((line_state == 2'b00) && !out_valid && !out_eof));

endmodule

bind hdlc_rx_filter hdlc_rx_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .out_valid(out_valid), .out_eof(out_eof), .out_err(out_err), .out_abort(out_abort),
  .line_state(line_state), .ev_flag(ev_flag), .ev_abort(ev_abort), .ev_byte(ev_byte),
  .frame_reject(frame_reject)
);

// File: tb/hdlc_rx_filter_tb.sv
module hdlc_rx_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b1;
  logic        filt_en = 1'b0;
  logic        filt_two_byte = 1'b0;
  logic [31:0] filt_addrs = {8'hC4, 8'h3A, 8'h21, 8'h02};
  logic        fcs_check = 1'b1;
  logic        fcs_keep = 1'b0;
  logic        out_valid, out_eof, out_err, out_abort;
  logic [7:0]  out_data;
  logic [1:0]  line_state;

  always #5 clk = ~clk;

  hdlc_rx_filter u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bit_valid(bit_valid), .bit_in(bit_in),
    .filt_en(filt_en), .filt_two_byte(filt_two_byte), .filt_addrs(filt_addrs),
    .fcs_check(fcs_check), .fcs_keep(fcs_keep),
    .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof), .out_err(out_err),
    .out_abort(out_abort), .line_state(line_state)
  );

  int n_checks = 0;
  int n_fail = 0;
  int tx_ones = 0;
  bit use_gaps = 1'b0;

  logic [7:0] fr [0:31];
  logic [7:0] got [0:63];
  int got_n = 0;
  int eof_n = 0;
  logic last_err = 1'b0;
  logic last_abort = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (got_n < 64) got[got_n] = out_data;
        got_n++;
      end
      if (out_eof) begin
        eof_n++;
        last_err = out_err;
        last_abort = out_abort;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] bench_crc(input int len);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++)
        c = (c >> 1) ^ ({16{c[0] ^ fr[i][b]}} & 16'h8408);
    return c;
  endfunction

  function automatic bit bench_accept(input int total);
    if (!filt_en) return 1'b1;
    if (!filt_two_byte) begin
      for (int k = 0; k < 4; k++) if (fr[0] == filt_addrs[8*k +: 8]) return 1'b1;
      return 1'b0;
    end
    if (total < 2) return 1'b1;
    return (fr[0] == filt_addrs[7:0]   && fr[1] == filt_addrs[15:8]) ||
           (fr[0] == filt_addrs[23:16] && fr[1] == filt_addrs[31:24]);
  endfunction

  task automatic tx_bit(input logic b);
    bit_in = b;
    bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    if (use_gaps) repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic tx_flag();
    for (int i = 0; i < 8; i++) tx_bit(8'h7E >> i);
    tx_ones = 0;
  endtask

  task automatic tx_ones_run(input int n);
    for (int i = 0; i < n; i++) tx_bit(1'b1);
    tx_ones = 0;
  endtask

  task automatic tx_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      tx_bit(b[i]);
      if (b[i]) begin
        tx_ones++;
        if (tx_ones == 5) begin
          tx_bit(1'b0);
          tx_ones = 0;
        end
      end else tx_ones = 0;
    end
  endtask

  // fcs_mode: 0 none, 1 good, 2 corrupted. fr[0..n-1] holds the payload.
  task automatic run_frame(input int n, input int fcs_mode, input int idle_after);
    logic [15:0] c;
    int total, exp_n;
    bit acc, keep_all, exp_err;
    total = n;
    if (fcs_mode != 0) begin
      c = ~bench_crc(n);
      if (fcs_mode == 2) c = c ^ 16'h0100;
      fr[n] = c[7:0];
      fr[n+1] = c[15:8];
      total = n + 2;
    end
    got_n = 0;
    eof_n = 0;
    tx_flag();
    for (int i = 0; i < total; i++) begin
      tx_byte(fr[i]);
      if (i == 0 && !filt_en)
        check(line_state == 2'b10, "R3", "line_state in frame", line_state, 2);
    end
    tx_flag();
    repeat (8) @(negedge clk);
    if (idle_after > 0) tx_ones_run(idle_after);
    acc = bench_accept(total);
    keep_all = !fcs_check || fcs_keep;
    exp_n = !acc ? 0 : keep_all ? total : (total >= 2 ? total - 2 : 0);
    exp_err = (total < 3) || (fcs_check && fcs_mode != 1);
    check(got_n == exp_n, acc ? "R8/R10" : "R7", "byte count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      check(got[i] == fr[i], "R2", "frame byte", got[i], fr[i]);
    check(eof_n == (acc ? 1 : 0), acc ? "R8" : "R7", "eof beats", eof_n, acc ? 1 : 0);
    if (acc && eof_n == 1) begin
      check(last_err == exp_err, total < 3 ? "R11" : "R9", "err flag", last_err, exp_err);
      check(last_abort == 1'b0, "R12", "abort flag", last_abort, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(line_state == 2'b00 && !out_valid && !out_eof, "R1", "reset state", line_state, 0);
    enable = 1'b1;
    tx_ones_run(10);
    check(line_state == 2'b00, "R1", "hunt on idle ones", line_state, 0);
    tx_flag();
    check(line_state == 2'b01, "R1", "after flag", line_state, 1);

    // Good frame, strip check bytes; stuffing-heavy payload
    fr[0] = 8'hFF; fr[1] = 8'h7E; fr[2] = 8'h3F; fr[3] = 8'h1F; fr[4] = 8'hF8;
    run_frame(5, 1, 0);
    fcs_keep = 1'b1;                     // R10 keep
    run_frame(5, 1, 0);
    fcs_keep = 1'b0;
    run_frame(5, 2, 9);                  // R9 corrupted
    fcs_check = 1'b0;                    // R10 bypass: corrupted but no error
    run_frame(5, 2, 0);
    fcs_check = 1'b1;

    // R11 short frames
    fr[0] = 8'h55; fr[1] = 8'hAA;
    run_frame(2, 0, 0);
    fcs_check = 1'b0;
    run_frame(1, 0, 0);
    fcs_check = 1'b1;

    // R4 abort mid-frame: three bytes in, one has left the hold pipe
    got_n = 0; eof_n = 0;
    tx_flag();
    tx_byte(8'h11); tx_byte(8'h22); tx_byte(8'h33);
    tx_ones_run(8);
    repeat (4) @(negedge clk);
    check(got_n == 1 && got[0] == 8'h11, "R4", "bytes before abort", got_n, 1);
    check(eof_n == 1 && last_abort && !last_err, "R4", "abort beat", {last_abort, last_err}, 2);
    check(line_state == 2'b00, "R4", "hunt after abort", line_state, 0);

    // R5 single-byte filter, R7 bit 0 not masked
    filt_en = 1'b1;
    fr[0] = 8'hC4; fr[1] = 8'h99;
    run_frame(2, 1, 0);
    fr[0] = 8'h3A;
    run_frame(2, 1, 0);
    fr[0] = 8'h03;                       // reg0 is 0x02
    run_frame(2, 1, 0);
    check(line_state == 2'b01, "R7", "resynced on closing flag", line_state, 1);

    // R6 paired filter
    filt_two_byte = 1'b1;
    fr[0] = 8'h3A; fr[1] = 8'hC4; fr[2] = 8'h01;
    run_frame(3, 1, 0);
    fr[0] = 8'h02; fr[1] = 8'hC4;        // crossed pair
    run_frame(3, 1, 0);
    fr[0] = 8'h02; fr[1] = 8'h21;
    run_frame(3, 1, 0);
    filt_two_byte = 1'b0;
    filt_en = 1'b0;

    // R1 disable returns to hunt
    enable = 1'b0;
    @(negedge clk);
    check(line_state == 2'b00, "R1", "disabled", line_state, 0);
    enable = 1'b1;

    // Random frames with random settings and bit gaps
    use_gaps = 1'b1;
    for (int t = 0; t < 40; t++) begin
      int n, sel;
      n = 1 + ($urandom % 8);
      for (int i = 0; i < n; i++) fr[i] = 8'($urandom);
      filt_en = 1'($urandom);
      filt_two_byte = 1'($urandom);
      fcs_check = 1'($urandom);
      fcs_keep = 1'($urandom);
      sel = $urandom % 4;
      if (sel != 0 && n >= 2) begin
        int p;
        p = $urandom % 2;
        fr[0] = filt_addrs[16*p +: 8];
        fr[1] = (sel == 3) ? 8'($urandom) : filt_addrs[16*p + 8 +: 8];
        if (!filt_two_byte && sel == 2) fr[0] = filt_addrs[8*($urandom % 4) +: 8];
      end
      run_frame(n, 1 + ($urandom % 2), ($urandom % 2) * 8);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule